// File: doc/BRIEF.md
# Clock-Sampled Pseudo-SRAM Device Model

This block stands in for a word-wide nonvolatile memory that has an asynchronous pseudo-SRAM pin interface. A fast system clock samples every pin and finds its edges. A small mode machine then runs the device the way the pins ask. A chip-enable falling edge opens an access. When write enable is high, that access is a read of the addressed word, and each later address change while the chip stays enabled starts a fresh read. A write-enable falling edge, or a chip-enable falling edge while write enable is already low, opens a write. The write stores the input data on whichever strobe rises first. Each chip-enable rising edge starts a precharge period that lasts a set number of cycles.

The 16-bit data bus is split into an input word, an output word and one output-enable bit per byte lane, so surrounding logic or a pad ring can build the shared bus. The lower byte enable gates bits 7:0 and the upper byte enable gates bits 15:8, on reads and on writes. A sticky error flag records timing and protocol violations: an access that is too short, a start attempted during precharge, and a byte-enable change in the middle of a write.

Top module: `psram_emu`

## Requirements
- R1: After reset, both lane drive bits are 0, the error flag is 0 and every stored word reads back as 0x0000.
- R2: A chip-enable fall while write enable is high, followed by output enable low, drives the word stored at the sampled address. dq_oe bit 0 is set when lb_n is low and bit 1 when ub_n is low.
- R3: While chip enable stays low, a change of address makes dq_out show the word at the new address.
- R4: In a write started by a write-enable fall, dq_oe is 0 while write enable is low. On the write-enable rise the data is stored, and dq_out then shows the updated word.
- R5: If write enable is low before chip enable falls, no lane is driven, and the data is stored on the chip-enable rise.
- R6: With oe_n high, or with both lb_n and ub_n high, dq_oe is 0 whatever the other pins do.
- R7: A write with one byte enable high leaves that lane's stored byte unchanged.
- R8: A chip-enable fall inside the PRE_CYC-cycle precharge window starts no access: nothing is driven, nothing is stored, and err rises.
- R9: A chip-enable rise fewer than MIN_ACT cycles after an access opened sets err.
- R10: A change on lb_n or ub_n during a write sets err.
- R11: While zz_n is low no lane is driven and no access starts. Stored words survive sleep, and a chip-enable fall is needed after wake-up.
- R12: Once err is set it stays set until reset. A violation-free access leaves it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte (bits 7:0) enable, active low |
| ub_n | input | 1 | Upper byte (bits 15:8) enable, active low |
| zz_n | input | 1 | Sleep request, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-lane output enable: bit 0 lower byte, bit 1 upper byte |
| err | output | 1 | Sticky violation flag |

## Verification
The bench writes a word, writes a single lane over it, and reads the word back. A model that ignored the byte enables would overwrite the protected byte. It then moves the address while the chip stays enabled, to catch a model that only reads on the chip-enable edge. It opens a write with write enable already low, to catch a model that drives the bus or stores on the wrong strobe. It tries a chip-enable fall inside the precharge window, and a model that did not block it would store data and leave err low. The short-access, byte-enable-change and sleep cases show whether the error flag stays sticky and whether a wake-up wrongly starts an access without a new falling edge.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int LANES  = 2;
    localparam int LANE_W = 8;
    localparam int DATA_W = LANES * LANE_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
        logic lb_n;
        logic ub_n;
        logic zz_n;
    } ctl_t;

    typedef struct packed {
        logic ce_fall;
        logic ce_rise;
        logic we_fall;
        logic we_rise;
        logic addr_chg;
        logic lane_chg;
    } edge_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_PRE,
        ST_SLEEP
    } mode_t;

    localparam ctl_t CTL_INACTIVE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                      lb_n: 1'b1, ub_n: 1'b1, zz_n: 1'b1};

    function automatic word_t lane_merge(input word_t old_w, input word_t new_w,
                                         input logic [LANES-1:0] en);
        word_t r;
        for (int i = 0; i < LANES; i++)
            r[i*LANE_W +: LANE_W] = en[i] ? new_w[i*LANE_W +: LANE_W]
                                          : old_w[i*LANE_W +: LANE_W];
        return r;
    endfunction

endpackage

// File: rtl/psram_pin_sampler.sv
module psram_pin_sampler
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              pin_ctl,
    input  logic [ADDR_W-1:0] pin_addr,
    input  word_t             pin_dq,
    output ctl_t              s_ctl,
    output edge_t             ev,
    output logic [ADDR_W-1:0] s_addr,
    output logic [LANES-1:0]  p_lane_n,
    output word_t             p_dq
);
    ctl_t              p_ctl;
    logic [ADDR_W-1:0] p_addr;
    word_t             s_dq;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_ctl  <= CTL_INACTIVE;
            p_ctl  <= CTL_INACTIVE;
            s_addr <= '0;
            p_addr <= '0;
            s_dq   <= '0;
            p_dq   <= '0;
        end else begin
            s_ctl  <= pin_ctl;
            p_ctl  <= s_ctl;
            s_addr <= pin_addr;
            p_addr <= s_addr;
            s_dq   <= pin_dq;
            p_dq   <= s_dq;
        end
    end

    always_comb begin
        ev.ce_fall  = p_ctl.ce_n  & ~s_ctl.ce_n;
        ev.ce_rise  = ~p_ctl.ce_n &  s_ctl.ce_n;
        ev.we_fall  = p_ctl.we_n  & ~s_ctl.we_n;
        ev.we_rise  = ~p_ctl.we_n &  s_ctl.we_n;
        ev.addr_chg = (s_addr != p_addr);
        ev.lane_chg = (s_ctl.lb_n != p_ctl.lb_n) | (s_ctl.ub_n != p_ctl.ub_n);
    end

    assign p_lane_n = {p_ctl.ub_n, p_ctl.lb_n};
endmodule

// File: rtl/psram_lane_store.sv
module psram_lane_store
    import psram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_en,
    input  word_t             wdata,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
            end else if (wr_en && lane_en[g]) begin
                bank[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[addr];
    end
endmodule

// File: rtl/psram_mode_fsm.sv
module psram_mode_fsm
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int PRE_CYC = 4,
    parameter int MIN_ACT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              s_ctl,
    input  edge_t             ev,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [LANES-1:0]  p_lane_n,
    input  word_t             p_dq,
    input  word_t             mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [LANES-1:0]  mem_lane,
    output word_t             rd_word,
    output logic [LANES-1:0]  drive,
    output logic              err
);
    localparam int PC_W = $clog2(PRE_CYC + 1);
    localparam int AC_W = $clog2(MIN_ACT + 1);

    mode_t             st;
    logic [ADDR_W-1:0] cur_addr;
    logic [PC_W-1:0]   pc_cnt;
    logic [AC_W-1:0]   act_cnt;
    logic              act_short;
    logic              strobe_up;
    word_t             merged;

    assign act_short = (act_cnt < AC_W'(MIN_ACT));
    assign strobe_up = ev.ce_rise | ev.we_rise;
    assign mem_addr  = (st == ST_WRITE) ? cur_addr : s_addr;
    assign mem_lane  = ~p_lane_n;
    assign mem_wr    = (st == ST_WRITE) && strobe_up && s_ctl.zz_n;
    assign merged    = lane_merge(mem_rdata, p_dq, mem_lane);

    assign drive = {LANES{(st == ST_READ) && !s_ctl.ce_n && !s_ctl.oe_n && s_ctl.zz_n}}
                 & ~{s_ctl.ub_n, s_ctl.lb_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur_addr <= '0;
            rd_word  <= '0;
            pc_cnt   <= '0;
            act_cnt  <= '0;
            err      <= 1'b0;
        end else begin
            if ((st == ST_READ || st == ST_WRITE) && act_short)
                act_cnt <= act_cnt + 1'b1;

            if (!s_ctl.zz_n) begin
                st <= ST_SLEEP;
            end else begin
                case (st)
                    ST_SLEEP: st <= ST_IDLE;
                    ST_IDLE: begin
                        if (ev.ce_fall) begin
                            cur_addr <= s_addr;
                            rd_word  <= mem_rdata;
                            act_cnt  <= '0;
                            st       <= s_ctl.we_n ? ST_READ : ST_WRITE;
                        end
                    end
                    ST_READ: begin
                        if (ev.ce_rise) begin
                            if (act_short) err <= 1'b1;
                            pc_cnt <= PC_W'(PRE_CYC);
                            st     <= ST_PRE;
                        end else if (ev.we_fall) begin
                            cur_addr <= s_addr;
                            st       <= ST_WRITE;
                        end else if (ev.addr_chg) begin
                            cur_addr <= s_addr;
                            rd_word  <= mem_rdata;
                        end
                    end
                    ST_WRITE: begin
                        if (ev.lane_chg) err <= 1'b1;
                        if (strobe_up) begin
                            rd_word <= merged;
                            if (ev.ce_rise) begin
                                if (act_short) err <= 1'b1;
                                pc_cnt <= PC_W'(PRE_CYC);
                                st     <= ST_PRE;
                            end else begin
                                st <= ST_READ;
                            end
                        end
                    end
                    ST_PRE: begin
                        if (ev.ce_fall) err <= 1'b1;
                        if (pc_cnt <= PC_W'(1)) st <= ST_IDLE;
                        else                    pc_cnt <= pc_cnt - 1'b1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(err) |-> err);
endmodule

// File: rtl/psram_emu.sv
module psram_emu
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int PRE_CYC = 4,
    parameter int MIN_ACT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic              zz_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [1:0]        dq_oe,
    output logic              err
);
    ctl_t              pin_ctl, s_ctl;
    edge_t             ev;
    logic [ADDR_W-1:0] s_addr, mem_addr;
    logic [LANES-1:0]  p_lane_n, mem_lane;
    word_t             p_dq, mem_rdata, rd_word;
    logic              mem_wr;

    assign pin_ctl = '{ce_n: ce_n, we_n: we_n, oe_n: oe_n,
                       lb_n: lb_n, ub_n: ub_n, zz_n: zz_n};

    psram_pin_sampler #(.ADDR_W(ADDR_W)) u_sampler (
        .clk(clk), .rst(rst), .pin_ctl(pin_ctl), .pin_addr(addr), .pin_dq(dq_in),
        .s_ctl(s_ctl), .ev(ev), .s_addr(s_addr), .p_lane_n(p_lane_n), .p_dq(p_dq)
    );

    psram_mode_fsm #(.ADDR_W(ADDR_W), .PRE_CYC(PRE_CYC), .MIN_ACT(MIN_ACT)) u_fsm (
        .clk(clk), .rst(rst), .s_ctl(s_ctl), .ev(ev), .s_addr(s_addr),
        .p_lane_n(p_lane_n), .p_dq(p_dq), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_lane(mem_lane),
        .rd_word(rd_word), .drive(dq_oe), .err(err)
    );

    psram_lane_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst(rst), .addr(mem_addr), .wr_en(mem_wr),
        .lane_en(mem_lane), .wdata(p_dq), .rdata(mem_rdata)
    );

    assign dq_out = rd_word;

    // R6
    oe_high_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (oe_n && $past(oe_n)) |-> (dq_oe == 2'b00));

    // R11
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!zz_n && $past(!zz_n)) |-> (dq_oe == 2'b00));

    // R2
    drive_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (dq_oe != 2'b00) |-> !$past(ce_n));
endmodule

// File: tb/psram_emu_tb.sv
module psram_emu_tb;
    localparam int AW  = 6;
    localparam int PRE = 4;
    localparam int MNA = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic          lb_n = 1'b0, ub_n = 1'b0, zz_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out;
    logic [1:0]    dq_oe;
    logic          err;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [1<<AW];

    always #2.5 clk = ~clk;

    psram_emu #(.ADDR_W(AW), .PRE_CYC(PRE), .MIN_ACT(MNA)) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .zz_n(zz_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .err(err)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        lb_n = 1'b0; ub_n = 1'b0; zz_n = 1'b1;
        for (int i = 0; i < (1<<AW); i++) model[i] = 16'h0000;
        cyc(3);
        rst = 1'b0;
        cyc(2);
    endtask

    task automatic store_model(input int a, input logic [15:0] d,
                               input logic lb, input logic ub);
        if (!lb) model[a][7:0]  = d[7:0];
        if (!ub) model[a][15:8] = d[15:8];
    endtask

    // WE-controlled write (R4, R7)
    task automatic wr_we(input logic [AW-1:0] a, input logic [15:0] d,
                         input logic lb, input logic ub, input string tag);
        @(negedge clk);
        addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; lb_n = lb; ub_n = ub;
        cyc(4);
        we_n = 1'b0; dq_in = d;
        cyc(3);
        check(dq_oe == 2'b00, {tag, " R4 bus released while WE low"}, dq_oe, 0);
        we_n = 1'b1;
        cyc(3);
        store_model(a, d, lb, ub);
        check(dq_out == model[a], {tag, " R4 word after WE rise"}, dq_out, model[a]);
        ce_n = 1'b1; oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
        cyc(PRE + 6);
    endtask

    // CE-controlled write (R5)
    task automatic wr_ce(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; we_n = 1'b0; oe_n = 1'b0; dq_in = d;
        cyc(2);
        ce_n = 1'b0;
        cyc(4);
        check(dq_oe == 2'b00, "R5 no drive in CE-controlled write", dq_oe, 0);
        ce_n = 1'b1;
        cyc(2);
        we_n = 1'b1; oe_n = 1'b1;
        store_model(a, d, 1'b0, 1'b0);
        cyc(PRE + 6);
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic lb, input logic ub,
                      input logic oe, input string tag);
        logic [1:0]  eoe;
        logic [15:0] mask;
        @(negedge clk);
        addr = a; we_n = 1'b1; oe_n = oe; lb_n = lb; ub_n = ub; ce_n = 1'b0;
        cyc(5);
        eoe  = oe ? 2'b00 : {~ub, ~lb};
        mask = {{8{eoe[1]}}, {8{eoe[0]}}};
        check(dq_oe == eoe, {tag, " lane drive"}, dq_oe, eoe);
        check((dq_out & mask) == (model[a] & mask), {tag, " read data"},
              dq_out & mask, model[a] & mask);
        ce_n = 1'b1; oe_n = 1'b1; lb_n = 1'b0; ub_n = 1'b0;
        cyc(PRE + 6);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(dq_oe == 2'b00, "R1 no drive after reset", dq_oe, 0);
        check(err == 1'b0, "R1 err clear after reset", err, 0);
    endtask

    task automatic t_addr_change();
        @(negedge clk);
        addr = 6'd5; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        cyc(5);
        check(dq_out == model[5], "R3 first address", dq_out, model[5]);
        addr = 6'd9;
        cyc(4);
        check(dq_out == model[9], "R3 new address while CE low", dq_out, model[9]);
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(PRE + 6);
    endtask

    task automatic t_sleep();
        @(negedge clk);
        zz_n = 1'b0;
        cyc(2);
        addr = 6'd12; oe_n = 1'b0; ce_n = 1'b0;
        cyc(5);
        check(dq_oe == 2'b00, "R11 no drive while asleep", dq_oe, 0);
        zz_n = 1'b1;
        cyc(4);
        check(dq_oe == 2'b00, "R11 wake-up without CE fall starts nothing", dq_oe, 0);
        ce_n = 1'b1; oe_n = 1'b1;
        cyc(PRE + 6);
        rd(6'd12, 1'b0, 1'b0, 1'b0, "R11 data kept over sleep");
    endtask

    task automatic t_precharge();
        @(negedge clk);
        addr = 6'd12; we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
        cyc(5);
        ce_n = 1'b1; we_n = 1'b0; dq_in = 16'hFFFF;
        cyc(2);
        ce_n = 1'b0;
        cyc(6);
        check(dq_oe == 2'b00, "R8 no drive for CE fall in precharge", dq_oe, 0);
        check(err == 1'b1, "R8 err on CE fall in precharge", err, 1);
        ce_n = 1'b1;
        cyc(2);
        we_n = 1'b1; oe_n = 1'b1;
        cyc(PRE + 6);
        rd(6'd12, 1'b0, 1'b0, 1'b0, "R8 word not stored");
    endtask

    task automatic t_short_access();
        do_reset();
        @(negedge clk);
        addr = 6'd3; ce_n = 1'b0;
        cyc(1);
        ce_n = 1'b1;
        cyc(PRE + 6);
        check(err == 1'b1, "R9 err on short access", err, 1);
    endtask

    task automatic t_lane_change();
        do_reset();
        @(negedge clk);
        addr = 6'd4; we_n = 1'b0; dq_in = 16'h5A5A; ce_n = 1'b0;
        cyc(3);
        check(err == 1'b0, "R10 err clear before change", err, 0);
        lb_n = 1'b1;
        cyc(3);
        ce_n = 1'b1;
        cyc(2);
        we_n = 1'b1; lb_n = 1'b0;
        cyc(PRE + 6);
        check(err == 1'b1, "R10 err on byte enable change in write", err, 1);
    endtask

    initial begin
        #500000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        rd(6'd5, 1'b0, 1'b0, 1'b0, "R1 array cleared");
        wr_we(6'd5, 16'hA5C3, 1'b0, 1'b0, "full");
        rd(6'd5, 1'b0, 1'b0, 1'b0, "R2 full word read");
        wr_we(6'd5, 16'h1234, 1'b0, 1'b1, "lower only");
        rd(6'd5, 1'b0, 1'b0, 1'b0, "R7 upper lane kept");
        rd(6'd5, 1'b1, 1'b0, 1'b0, "R6 upper lane only");
        rd(6'd5, 1'b0, 1'b0, 1'b1, "R6 OE high");
        rd(6'd5, 1'b1, 1'b1, 1'b0, "R6 both lanes off");
        wr_we(6'd9, 16'hBEEF, 1'b0, 1'b0, "second");
        t_addr_change();
        wr_ce(6'd12, 16'h0F0F);
        rd(6'd12, 1'b0, 1'b0, 1'b0, "R5 stored on CE rise");
        check(err == 1'b0, "R12 clean accesses leave err low", err, 0);
        t_sleep();
        check(err == 1'b0, "R11 sleep raises no err", err, 0);
        t_precharge();
        check(err == 1'b1, "R12 err stays after clean read", err, 1);
        do_reset();
        check(err == 1'b0, "R12 reset clears err", err, 0);
        t_short_access();
        t_lane_change();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule